// File: doc/BRIEF.md
# Configuration Image Loader

This block is a bus master that loads a programmable-logic configuration image. It fetches the image from word-addressed memory and pushes it, one word per transfer, into a configuration port. On a start pulse it first looks at the port's lock flag and refuses to run if the port is locked. Otherwise it raises the port's configuration-in-progress flag. It then reads the image header, compares the header's identification word with the device identification input, and works out where the payload starts and ends.

The payload is streamed with one read outstanding at a time. Each word is handed to the port with a one-cycle write strobe, and the next word is not fetched while the port reports busy. After the last word the loader waits for the port to drop its in-progress flag, then samples the port's error flag. The outcome is shown on a one-hot status output, which holds until the next start. A free-running enable pulse at one eighth of the bus clock paces the configuration logic.

Top module: `cfg_image_loader`

## Requirements
- R1: A start taken while idle with `cp_lock` high sets status to 4'b0010 (lock error) on the next cycle. The loader then issues no memory read and no `cp_co_set`.
- R2: A start taken while idle with `cp_lock` low drives `cp_co_set` high for exactly one cycle, on the cycle after the start, before any memory read.
- R3: The header is read at image base +4 (identification word), +8 (byte offset to the payload) and +12 (payload size in bytes), in that order. The word at the base address is never read.
- R4: An identification word that differs from `dev_id` sets status to 4'b0100 (ID error), and no configuration write is issued.
- R5: Payload words are read from base+offset upward in 4-byte steps, and each word is written to `cp_wdata` unchanged. Streaming stops once the next address reaches base+offset+size.
- R6: Each payload word gets exactly one single-cycle `cp_we`. From the cycle after the strobe, no further read is requested while `cp_busy` is 1.
- R7: A payload size of 0 issues no write and proceeds straight to waiting on `cp_co`.
- R8: After the payload, the loader waits for `cp_co` to be 0. It then reports status 4'b1000 (config error) if `cp_err` is 1, or 4'b0001 (done) otherwise.
- R9: Status is one-hot or zero. It clears on an accepted start, holds its value while idle, and a start received while the loader is running is ignored.
- R10: `cfg_clk_en` is a single-cycle pulse every `CLK_DIV` (default 8) cycles.
- R11: `mem_req` is a single-cycle pulse, and no new request is issued until `mem_rvalid` has returned for the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse |
| img_base | input | W | Byte address of the image header |
| dev_id | input | W | Device identification code |
| run | output | 1 | Loader is active |
| status | output | 4 | One-hot result: bit0 done, bit1 lock error, bit2 ID error, bit3 config error |
| mem_req | output | 1 | Memory read request pulse |
| mem_addr | output | W | Memory read byte address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | W | Read data |
| cp_lock | input | 1 | Configuration port locked |
| cp_busy | input | 1 | Port is absorbing the last word |
| cp_co | input | 1 | Configuration in progress flag |
| cp_err | input | 1 | Configuration error flag |
| cp_co_set | output | 1 | Pulse that sets the in-progress flag |
| cp_we | output | 1 | Data write strobe |
| cp_wdata | output | W | Configuration data word |
| cfg_clk_en | output | 1 | Divided configuration clock enable |

## Verification
A lock abort shows on status one cycle after the start edge. The in-progress pulse comes one cycle after an accepted start, and a write strobe comes one cycle after its read data returns. Busy is first sampled on the cycle after the strobe. Terminal status is due one cycle after `cp_co` is seen low, and the bench reads it only once `run` has fallen. Port and memory models count strobes, reads and data mismatches on clock edges. Checks sample at the falling edge, so every registered result has settled by the time it is read.

// File: rtl/cfg_image_loader.sv
module cfg_image_loader #(
  parameter int W       = 32,
  parameter int CLK_DIV = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] img_base,
  input  logic [W-1:0] dev_id,
  output logic         run,
  output logic [3:0]   status,
  output logic         mem_req,
  output logic [W-1:0] mem_addr,
  input  logic         mem_rvalid,
  input  logic [W-1:0] mem_rdata,
  input  logic         cp_lock,
  input  logic         cp_busy,
  input  logic         cp_co,
  input  logic         cp_err,
  output logic         cp_co_set,
  output logic         cp_we,
  output logic [W-1:0] cp_wdata,
  output logic         cfg_clk_en
);
  localparam int CW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [3:0] ST_DONE = 4'b0001, ST_LOCK = 4'b0010,
                         ST_ID   = 4'b0100, ST_CFG  = 4'b1000;

  typedef enum logic [3:0] {
    S_IDLE, S_SETCO, S_RID, S_ROFF, S_RSZ, S_RDAT, S_WR, S_WBUSY, S_WCO, S_END
  } state_t;

  state_t       state;
  logic         pend;
  logic [W-1:0] base_q, off_q, ptr_q, end_q, ptr_nx;
  logic [CW-1:0] div_cnt;

  wire reading = (state == S_RID) || (state == S_ROFF) ||
                 (state == S_RSZ) || (state == S_RDAT);
  wire got     = pend && mem_rvalid;

  assign run       = (state != S_IDLE) && (state != S_END);
  assign mem_req   = reading && !pend;
  assign cp_co_set = (state == S_SETCO);
  assign cp_we     = (state == S_WR);
  assign ptr_nx    = ptr_q + W'(4);

  always_comb begin
    case (state)
      S_RID:   mem_addr = base_q + W'(4);
      S_ROFF:  mem_addr = base_q + W'(8);
      S_RSZ:   mem_addr = base_q + W'(12);
      default: mem_addr = ptr_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      pend     <= 1'b0;
      status   <= '0;
      base_q   <= '0;
      off_q    <= '0;
      ptr_q    <= '0;
      end_q    <= '0;
      cp_wdata <= '0;
    end else begin
      if (mem_req)  pend <= 1'b1;
      else if (got) pend <= 1'b0;
      case (state)
        S_IDLE, S_END: if (start) begin
          base_q <= img_base;
          if (cp_lock) begin
            status <= ST_LOCK;
            state  <= S_END;
          end else begin
            status <= '0;
            state  <= S_SETCO;
          end
        end
        S_SETCO: state <= S_RID;
        S_RID: if (got) begin
          if (mem_rdata != dev_id) begin
            status <= ST_ID;
            state  <= S_END;
          end else state <= S_ROFF;
        end
        S_ROFF: if (got) begin
          off_q <= mem_rdata;
          state <= S_RSZ;
        end
        S_RSZ: if (got) begin
          ptr_q <= base_q + off_q;
          end_q <= base_q + off_q + mem_rdata;
          state <= (mem_rdata == '0) ? S_WCO : S_RDAT;
        end
        S_RDAT: if (got) begin
          cp_wdata <= mem_rdata;
          state    <= S_WR;
        end
        S_WR: state <= S_WBUSY;
        S_WBUSY: if (!cp_busy) begin
          ptr_q <= ptr_nx;
          state <= (ptr_nx >= end_q) ? S_WCO : S_RDAT;
        end
        S_WCO: if (!cp_co) begin
          status <= cp_err ? ST_CFG : ST_DONE;
          state  <= S_END;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                              div_cnt <= '0;
    else if (div_cnt == CW'(CLK_DIV - 1))    div_cnt <= '0;
    else                                     div_cnt <= div_cnt + 1'b1;
  end
  assign cfg_clk_en = rst_n && (div_cnt == CW'(CLK_DIV - 1));
endmodule

// File: rtl/cfg_image_loader_chk.sv
module cfg_image_loader_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         run,
  input logic [3:0]   status,
  input logic         mem_req,
  input logic         mem_rvalid,
  input logic [W-1:0] mem_rdata,
  input logic         cp_lock,
  input logic         cp_we,
  input logic         cp_co_set,
  input logic         cfg_clk_en
);
  logic outstanding;
  always_ff @(posedge clk) begin
    if (!rst_n)          outstanding <= 1'b0;
    else if (mem_req)    outstanding <= 1'b1;
    else if (mem_rvalid) outstanding <= 1'b0;
  end

  assert_lock_abort_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !run && cp_lock) |=> (status == 4'b0010 && !run && !mem_req));
  assert_co_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !run && !cp_lock) |=> (cp_co_set && !mem_req));
  assert_co_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cp_co_set |=> !cp_co_set);
  assert_we_after_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cp_we |-> $past(mem_rvalid));
  assert_we_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cp_we |=> (!cp_we && !mem_req));
  assert_status_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(status));
  assert_status_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !start) |=> $stable(status));
  assert_clk_en_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_clk_en |=> !cfg_clk_en);
  assert_one_outstanding_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (outstanding && !mem_rvalid) |-> !mem_req);
endmodule

bind cfg_image_loader cfg_image_loader_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .run(run), .status(status),
  .mem_req(mem_req), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
  .cp_lock(cp_lock), .cp_we(cp_we), .cp_co_set(cp_co_set),
  .cfg_clk_en(cfg_clk_en)
);

// File: tb/tb_cfg_image_loader.sv
module tb_cfg_image_loader;
  localparam int W = 32;
  localparam logic [31:0] BASE = 32'h1000_0000;
  localparam logic [31:0] DEV  = 32'h0ABC_D123;

  logic clk = 0, rst_n = 0, start = 0;
  logic run, mem_req, mem_rvalid, cp_lock, cp_busy, cp_co, cp_err;
  logic cp_co_set, cp_we, cfg_clk_en;
  logic [3:0] status;
  logic [W-1:0] mem_addr, mem_rdata, cp_wdata;
  logic [31:0] mem [64];

  always #5 clk = ~clk;

  cfg_image_loader #(.W(W), .CLK_DIV(8)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .img_base(BASE), .dev_id(DEV),
    .run(run), .status(status), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .cp_lock(cp_lock),
    .cp_busy(cp_busy), .cp_co(cp_co), .cp_err(cp_err), .cp_co_set(cp_co_set),
    .cp_we(cp_we), .cp_wdata(cp_wdata), .cfg_clk_en(cfg_clk_en));

  int n_rd, n_wr, n_co, n_bad, n_w0, n_busywr, tgt, offw, bcnt, ccnt;
  logic co_q;
  assign cp_busy = (bcnt != 0);
  assign cp_co   = co_q;

  always_ff @(posedge clk) begin
    mem_rvalid <= mem_req;
    mem_rdata  <= mem[mem_addr[7:2]];
    if (mem_req) begin
      n_rd <= n_rd + 1;
      if (mem_addr == BASE) n_w0 <= n_w0 + 1;
      if (bcnt != 0 && n_wr != 0) n_busywr <= n_busywr + 1;
    end
    if (cp_we) begin
      if (cp_wdata != mem[offw + n_wr]) n_bad <= n_bad + 1;
      n_wr <= n_wr + 1;
      bcnt <= 3;
    end else if (bcnt != 0) bcnt <= bcnt - 1;
    if (cp_co_set) begin
      n_co <= n_co + 1; co_q <= 1'b1; ccnt <= 0;
    end else if (co_q && n_wr == tgt) begin
      if (ccnt == 3) co_q <= 1'b0; else ccnt <= ccnt + 1;
    end
  end

  int tests = 0, fails = 0;
  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic setup(input bit lk, input bit idbad, input int ow, input int nw, input bit er);
    for (int i = 0; i < 64; i++) mem[i] = 32'hC0DE_0000 | i;
    mem[0] = 32'hFFFF_FFFF;
    mem[1] = idbad ? (DEV ^ 32'h1) : DEV;
    mem[2] = ow * 4;
    mem[3] = nw * 4;
    cp_lock = lk; cp_err = er; offw = ow; tgt = nw;
    n_rd = 0; n_wr = 0; n_co = 0; n_bad = 0; n_w0 = 0; n_busywr = 0;
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic wait_idle();
    while (run) @(negedge clk);
  endtask

  // fields: [19] lock [18] idbad [17:12] word offset [11:8] words [4] err [3:0] expected status
  localparam logic [19:0] VEC [6] = '{
    {1'b0, 1'b0, 6'd4,  4'd5, 3'd0, 1'b0, 4'b0001},
    {1'b0, 1'b0, 6'd10, 4'd3, 3'd0, 1'b1, 4'b1000},
    {1'b1, 1'b0, 6'd4,  4'd2, 3'd0, 1'b0, 4'b0010},
    {1'b0, 1'b1, 6'd4,  4'd2, 3'd0, 1'b0, 4'b0100},
    {1'b0, 1'b0, 6'd4,  4'd0, 3'd0, 1'b0, 4'b0001},
    {1'b0, 1'b0, 6'd8,  4'd1, 3'd0, 1'b0, 4'b0001}
  };

  initial begin
    int wd, ew, er, gap;
    logic [3:0] st0;
    wd = 0;
    fork
      begin
        repeat (20000) @(posedge clk);
        wd = 1;
      end
      begin
        setup(0, 0, 4, 1, 0); co_q = 0; bcnt = 0; ccnt = 0;
        repeat (3) @(negedge clk);
        check(status == 0 && !run && !mem_req && !cp_we && !cp_co_set, "reset R9", status, 0);
        rst_n = 1;

        for (int v = 0; v < 6; v++) begin
          setup(VEC[v][19], VEC[v][18], int'(VEC[v][17:12]), int'(VEC[v][11:8]), VEC[v][4]);
          pulse_start();
          if (VEC[v][19]) check(status == 4'b0010, "lock next cycle R1", status, 2);
          wait_idle();
          ew = (VEC[v][19] || VEC[v][18]) ? 0 : int'(VEC[v][11:8]);
          er = VEC[v][19] ? 0 : (VEC[v][18] ? 1 : 3 + int'(VEC[v][11:8]));
          check(status == VEC[v][3:0], "status R8", status, VEC[v][3:0]);
          check(n_wr == ew, "write count R4 R5 R7", n_wr, ew);
          check(n_bad == 0, "payload data R5", n_bad, 0);
          check(n_rd == er && n_w0 == 0, "header reads R3 R11", n_rd, er);
          check(n_co == (VEC[v][19] ? 0 : 1), "co pulse R2", n_co, VEC[v][19] ? 0 : 1);
          check(n_busywr == 0, "busy gating R6", n_busywr, 0);
        end

        st0 = status;
        repeat (20) @(negedge clk);
        check(status == st0, "status hold R9", status, st0);

        setup(0, 0, 4, 6, 0);
        pulse_start();
        repeat (5) @(negedge clk);
        pulse_start();
        wait_idle();
        check(status == 4'b0001 && n_wr == 6 && n_co == 1, "start ignored R9", n_wr, 6);

        while (!cfg_clk_en) @(negedge clk);
        gap = 0;
        @(negedge clk);
        while (!cfg_clk_en) begin gap++; @(negedge clk); end
        check(gap + 1 == 8, "clock enable R10", gap + 1, 8);
      end
    join_any
    if (wd) check(0, "watchdog", 0, 1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule